// File: doc/BRIEF.md
# Sequential Single-Precision Multiplier

This block multiplies two binary floating-point words in the 1-8-23 layout (sign in the top bit, 8-bit biased exponent, 23-bit fraction). A one-cycle `load` strobe captures both operands. The block then walks through a short fixed sequence of states and returns the packed product together with a one-cycle `done` strobe and two range flags. The product and the flags stay on the outputs until the next operation completes.

The exponent path has one adder only. That adder is used in four successive cycles: to add the two biased exponents, to remove the excess bias, to add the normalization increment, and to add the carry out of rounding. Zero, infinity and NaN operands are sorted out in the first working cycle, so the arithmetic path never sees them. The exponent range is checked before the significands are multiplied. An out-of-range result skips the multiply and finishes early. Normal results are rounded to nearest with ties to even.

Top module: `fp_mul_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `product` = 0 and `done`, `overflow` and `underflow` all low. A reset in the middle of an operation discards it, and no `done` follows.
- R2: `load` is sampled only when the unit is idle. A `load` pulse during an operation in flight is ignored: the result is that of the first operands and only one `done` pulse occurs.
- R3: `done` is high for exactly one cycle per accepted load. Counted in rising edges after the edge that samples `load`, it comes after 1 edge for a special operand, 3 edges for an out-of-range exponent and 6 edges otherwise. `product` and the flags change only together with `done`.
- R4: The sign of every non-NaN result, bit 31, is the XOR of the operand signs.
- R5: For normal operands the result exponent is Ex + Ey − 127, and the fraction is the rounded product of the significands with hidden bits (for example 2.0 × 3.0 = 0x40C00000).
- R6: An operand whose exponent field is 0 counts as zero, whatever its fraction. Zero times a finite value gives a signed zero with both flags low.
- R7: Infinity (exponent 255, fraction 0) times a nonzero non-NaN value gives a signed infinity with flags low. Zero times infinity, or any operand with exponent 255 and a nonzero fraction, gives 0x7FC00000.
- R8: If the biased result exponent exceeds 254, whether before the multiply or after normalization and rounding, the result is signed infinity (exponent 255, fraction 0) and `overflow` is high.
- R9: If Ex + Ey − 127 is below 1, the result is a signed zero and `underflow` is high. A value of exactly 1 gives a normal result.
- R10: A significand product in [2,4) is shifted right by one bit, and the exponent is raised by 1.
- R11: Rounding is to nearest, using a guard bit and a sticky OR of the lower product bits. A tie rounds to the even fraction.
- R12: When rounding carries out of the fraction, the fraction becomes 0 and the exponent rises by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start strobe, sampled when idle |
| op_a | input | 32 | First operand, packed |
| op_b | input | 32 | Second operand, packed |
| product | output | 32 | Packed result, held between operations |
| done | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | Result exponent above the largest finite value |
| underflow | output | 1 | Result exponent below the smallest normal value |

## Verification
The bench builds the unit with its default widths: an 8-bit exponent and a 23-bit fraction, so the bias is 127. These values put both range edges within reach of short vectors. A product of two values near 2^127 crosses the top end, either before the multiply or only after the normalization shift. A product of two values near 2^-126 crosses the bottom end, and the bench also checks the last exponent that still gives a normal result. The 24-bit significands let a few chosen operands land exactly on a rounding tie, or on the all-ones fraction that rounds up into the exponent.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SUM  = 3'd1,
        ST_BIAS = 3'd2,
        ST_CHK  = 3'd3,
        ST_MUL  = 3'd4,
        ST_NORM = 3'd5,
        ST_RND  = 3'd6
    } fpm_state_t;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      word,
    output logic              sgn,
    output logic [EXP_W-1:0]  expo,
    output logic [FRAC_W:0]   sig,
    output logic              is_zero,
    output logic              is_inf,
    output logic              is_nan
);
    logic [FRAC_W-1:0] frac;
    logic              exp_max;

    always_comb begin
        sgn     = word[W-1];
        expo    = word[W-2 -: EXP_W];
        frac    = word[FRAC_W-1:0];
        exp_max = &expo;
        // exponent field 0 is treated as zero; subnormal fractions are flushed
        is_zero = (expo == '0);
        is_inf  = exp_max && (frac == '0);
        is_nan  = exp_max && (frac != '0);
        sig     = {1'b1, frac};
    end

endmodule

// File: rtl/fpm_exp_adder.sv
module fpm_exp_adder #(
    parameter int EW = 10
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          sub,
    output logic [EW-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/fpm_norm_round.sv
module fpm_norm_round #(
    parameter int FRAC_W = 23,
    localparam int SW    = FRAC_W + 1,
    localparam int PW    = 2 * SW
) (
    input  logic [PW-1:0]     prod,
    output logic              hi,
    output logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] keep;
    logic              guard;
    logic              sticky;
    logic              up;
    logic [FRAC_W:0]   sum;

    always_comb begin
        hi = prod[PW-1];
        if (hi) begin
            keep   = prod[PW-2 -: FRAC_W];
            guard  = prod[PW-2-FRAC_W];
            sticky = |prod[PW-3-FRAC_W:0];
        end else begin
            keep   = prod[PW-3 -: FRAC_W];
            guard  = prod[PW-3-FRAC_W];
            sticky = |prod[PW-4-FRAC_W:0];
        end
        // nearest, ties to even
        up    = guard && (sticky || keep[0]);
        sum   = {1'b0, keep} + {{FRAC_W{1'b0}}, up};
        carry = sum[FRAC_W];
        frac  = sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/fp_mul_unit.sv
module fp_mul_unit
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = FRAC_W + 1,
    localparam int PW    = 2 * SW,
    localparam int EW    = EXP_W + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] product,
    output logic         done,
    output logic         overflow,
    output logic         underflow
);
    localparam logic [EW-1:0] BIAS_V  = EW'((1 << (EXP_W - 1)) - 1);
    localparam logic [EW-1:0] MAXE_V  = EW'((1 << EXP_W) - 2);
    localparam logic [EW-1:0] ONE_V   = EW'(1);
    localparam logic [W-2:0]  INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [W-1:0]  QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        fpm_state_t        st;
        logic [W-1:0]      a;
        logic [W-1:0]      b;
        logic              sgn;
        logic [EW-1:0]     expv;
        logic [PW-1:0]     prod;
        logic [FRAC_W-1:0] frac;
        logic              rcar;
        logic [W-1:0]      res;
        logic              done;
        logic              ovf;
        logic              udf;
    } regs_t;

    regs_t r_q, r_d;

    // operand unpack, one instance per captured operand
    logic [W-1:0]      opw   [2];
    logic              u_sgn [2];
    logic [EXP_W-1:0]  u_exp [2];
    logic [FRAC_W:0]   u_sig [2];
    logic              u_zer [2];
    logic              u_inf [2];
    logic              u_nan [2];

    assign opw[0] = r_q.a;
    assign opw[1] = r_q.b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unp
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
            .word    (opw[gi]),
            .sgn     (u_sgn[gi]),
            .expo    (u_exp[gi]),
            .sig     (u_sig[gi]),
            .is_zero (u_zer[gi]),
            .is_inf  (u_inf[gi]),
            .is_nan  (u_nan[gi])
        );
    end

    // single shared exponent adder
    logic [EW-1:0] add_a, add_b, add_y;
    logic          add_sub;

    fpm_exp_adder #(.EW(EW)) u_add (
        .a   (add_a),
        .b   (add_b),
        .sub (add_sub),
        .y   (add_y)
    );

    // normalization and rounding of the stored product
    logic              nr_hi;
    logic [FRAC_W-1:0] nr_frac;
    logic              nr_carry;

    fpm_norm_round #(.FRAC_W(FRAC_W)) u_nr (
        .prod  (r_q.prod),
        .hi    (nr_hi),
        .frac  (nr_frac),
        .carry (nr_carry)
    );

    logic s_x;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        add_a   = '0;
        add_b   = '0;
        add_sub = 1'b0;
        s_x     = u_sgn[0] ^ u_sgn[1];

        case (r_q.st)
            ST_IDLE: begin
                if (load) begin
                    r_d.a  = op_a;
                    r_d.b  = op_b;
                    r_d.st = ST_SUM;
                end
            end

            ST_SUM: begin
                r_d.sgn = s_x;
                add_a   = {2'b00, u_exp[0]};
                add_b   = {2'b00, u_exp[1]};
                if (u_nan[0] || u_nan[1] || (u_zer[0] && u_inf[1]) || (u_inf[0] && u_zer[1])) begin
                    r_d.res  = QNAN;
                    r_d.ovf  = 1'b0;
                    r_d.udf  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (u_inf[0] || u_inf[1]) begin
                    r_d.res  = {s_x, INF_MAG};
                    r_d.ovf  = 1'b0;
                    r_d.udf  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (u_zer[0] || u_zer[1]) begin
                    r_d.res  = {s_x, {(W-1){1'b0}}};
                    r_d.ovf  = 1'b0;
                    r_d.udf  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.expv = add_y;
                    r_d.st   = ST_BIAS;
                end
            end

            ST_BIAS: begin
                add_a    = r_q.expv;
                add_b    = BIAS_V;
                add_sub  = 1'b1;
                r_d.expv = add_y;
                r_d.st   = ST_CHK;
            end

            ST_CHK: begin
                if ($signed(r_q.expv) > $signed(MAXE_V)) begin
                    r_d.res  = {r_q.sgn, INF_MAG};
                    r_d.ovf  = 1'b1;
                    r_d.udf  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if ($signed(r_q.expv) < $signed(ONE_V)) begin
                    r_d.res  = {r_q.sgn, {(W-1){1'b0}}};
                    r_d.ovf  = 1'b0;
                    r_d.udf  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_MUL;
                end
            end

            ST_MUL: begin
                r_d.prod = PW'(u_sig[0]) * PW'(u_sig[1]);
                r_d.st   = ST_NORM;
            end

            ST_NORM: begin
                add_a    = r_q.expv;
                add_b    = {{(EW-1){1'b0}}, nr_hi};
                r_d.expv = add_y;
                r_d.frac = nr_frac;
                r_d.rcar = nr_carry;
                r_d.st   = ST_RND;
            end

            ST_RND: begin
                add_a    = r_q.expv;
                add_b    = {{(EW-1){1'b0}}, r_q.rcar};
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                if ($signed(add_y) > $signed(MAXE_V)) begin
                    r_d.res = {r_q.sgn, INF_MAG};
                    r_d.ovf = 1'b1;
                    r_d.udf = 1'b0;
                end else begin
                    r_d.res = {r_q.sgn, add_y[EXP_W-1:0], r_q.frac};
                    r_d.ovf = 1'b0;
                    r_d.udf = 1'b0;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign product   = r_q.res;
    assign done      = r_q.done;
    assign overflow  = r_q.ovf;
    assign underflow = r_q.udf;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] product,
    input logic         done,
    input logic         overflow,
    input logic         underflow
);
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    // R1: reset clears the outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !overflow && !underflow && product == '0));

    // R3: the done strobe lasts one cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: the result moves only together with done
    a_r3_result_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(product) |-> done);

    // R3: the flags move only together with done
    a_r3_flags_held: assert property (@(posedge clk) disable iff (rst)
        (!$stable(overflow) || !$stable(underflow)) |-> done);

    // R8: overflow always comes with infinity
    a_r8_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (product[W-2:0] == INF_MAG));

    // R9: underflow always comes with zero
    a_r9_udf_is_zero: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (product[W-2:0] == '0));

    // R8, R9: both flags are never high together
    a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

endmodule

bind fp_mul_unit fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .product   (product),
    .done      (done),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/fp_mul_unit_tb.sv
`timescale 1ns/1ps
module fp_mul_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] product;
    logic        done;
    logic        overflow;
    logic        underflow;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    fp_mul_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .op_a      (op_a),
        .op_b      (op_b),
        .product   (product),
        .done      (done),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // a, b, expected product, ovf, udf, latency, requirement number
    localparam int NV = 21;
    localparam logic [105:0] VEC [NV] = '{
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0, 4'd6, 4'd5},  // R5
        {32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0, 4'd6, 4'd5},  // R5
        {32'hC0000000, 32'h3F000000, 32'hBF800000, 1'b0, 1'b0, 4'd6, 4'd4},  // R4
        {32'h40400000, 32'hC0400000, 32'hC1100000, 1'b0, 1'b0, 4'd6, 4'd4},  // R4
        {32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, 4'd6, 4'd10}, // R10
        {32'h00000000, 32'h40A00000, 32'h00000000, 1'b0, 1'b0, 4'd1, 4'd6},  // R6
        {32'h80000000, 32'h40A00000, 32'h80000000, 1'b0, 1'b0, 4'd1, 4'd6},  // R6
        {32'h00000001, 32'h3F800000, 32'h00000000, 1'b0, 1'b0, 4'd1, 4'd6},  // R6 flushed fraction
        {32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0, 4'd1, 4'd7},  // R7
        {32'h00000000, 32'h7F800000, 32'h7FC00000, 1'b0, 1'b0, 4'd1, 4'd7},  // R7
        {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, 4'd1, 4'd7},  // R7
        {32'h7F000000, 32'h7F000000, 32'h7F800000, 1'b1, 1'b0, 4'd3, 4'd8},  // R8 early
        {32'h7F400000, 32'h3FC00000, 32'h7F800000, 1'b1, 1'b0, 4'd6, 4'd8},  // R8 after shift
        {32'h7F000000, 32'h3FC00000, 32'h7F400000, 1'b0, 1'b0, 4'd6, 4'd8},  // R8 top edge
        {32'h80800000, 32'h00800000, 32'h80000000, 1'b0, 1'b1, 4'd3, 4'd9},  // R9
        {32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, 4'd3, 4'd9},  // R9 exp 0
        {32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, 4'd6, 4'd9},  // R9 exp 1
        {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0, 4'd6, 4'd11}, // R11 tie, odd
        {32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0, 1'b0, 4'd6, 4'd11}, // R11 tie, even
        {32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0, 4'd6, 4'd11}, // R11 below half
        {32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 1'b0, 1'b0, 4'd6, 4'd12}  // R12
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one operation and wait for done; lat counts edges after the load edge
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, output int lat);
        @(negedge clk);
        op_a = a;
        op_b = b;
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        lat = 99;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_err++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int lat;
        int pulses;
        logic [31:0] ra;
        logic [31:0] rb;
        logic [31:0] rexp;
        logic        rovf;
        logic        rudf;
        int          rlat;
        int          rreq;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(product == 32'h0 && !done && !overflow && !underflow, "R1 reset state",
              {29'h0, done, overflow, underflow} | product, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {ra, rb, rexp, rovf, rudf} = VEC[i][105:8];
            rlat = int'(VEC[i][7:4]);
            rreq = int'(VEC[i][3:0]);
            run_op(ra, rb, lat);
            check(product == rexp, $sformatf("R%0d product vec %0d", rreq, i), product, rexp);
            check(overflow == rovf && underflow == rudf, $sformatf("R%0d flags vec %0d", rreq, i),
                  {30'h0, overflow, underflow}, {30'h0, rovf, rudf});
            check(lat == rlat, $sformatf("R3 latency vec %0d", i), 32'(lat), 32'(rlat));
            @(negedge clk);
            check(!done, $sformatf("R3 done width vec %0d", i), {31'h0, done}, 32'h0);
        end

        // R3: flags held after an overflow until the next result
        run_op(32'h7F000000, 32'h7F000000, lat);
        repeat (5) @(negedge clk);
        check(overflow && product == 32'h7F800000, "R3 overflow held", product, 32'h7F800000);
        run_op(32'h3F800000, 32'h40000000, lat);
        check(!overflow && product == 32'h40000000, "R3 flag cleared by next result", product, 32'h40000000);

        // R2: load pulse while busy is ignored
        @(negedge clk);
        op_a = 32'h3FC00000;
        op_b = 32'h3FC00000;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        op_a = 32'h40400000;
        op_b = 32'h40400000;
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        pulses = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check(product == 32'h40100000, "R2 busy load ignored", product, 32'h40100000);
        check(pulses == 1, "R2 single done", 32'(pulses), 32'd1);

        // R1: reset during an operation discards it
        @(negedge clk);
        op_a = 32'h40400000;
        op_b = 32'h40400000;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pulses = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check(product == 32'h0 && pulses == 0, "R1 reset mid operation", product, 32'h0);

        // R4: negative times negative is positive
        run_op(32'hC0000000, 32'hC0400000, lat);
        check(product == 32'h40C00000, "R4 neg times neg", product, 32'h40C00000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule